// File: doc/BRIEF.md
# Sticky Event Interrupt Controller

This block gathers a set of status-change events from the rest of a physical-layer transceiver and turns them into a single interrupt pin. Each event pulse is caught in a sticky flag that stays set until software reads it. Per-event mask bits select which flags may drive the pin. Masks and flags sit together in one management register: the masks form the upper half and the flags form the lower half. Reading that register returns both halves and clears the flags in the same access.

A separate polarity bit, which lives in a vendor control register, sets whether the pin is active-high or active-low. Active-low is the reset state. The management port supplies single-cycle read and write strobes. The register value is presented combinationally from internal state, so a read strobe samples the flags as they were before that read clears them.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the masks are 0, the flags are 0, the polarity bit is 0 (active-low) and irq_o is 1, which is its inactive level.
- R2: Any event bit high at a clock edge sets its flag, whatever the value of its mask bit. The flag stays set until a clearing read.
- R3: A read strobe clears every flag at that edge. An event bit that is high in the same cycle as the read leaves its flag set, so no event is lost.
- R4: reg_rdata_o always shows the masks in bits 15:8 and the flags in bits 7:0. Flag n pairs with mask bit n+8.
- R5: A write strobe loads bits 15:8 of reg_wdata_i into the masks at that edge. Bits 7:0 of the write data do not change any flag.
- R6: The interrupt is pending while the bitwise AND of the masks and the flags is nonzero. A mask write or an event changes the pin on the cycle after its edge.
- R7: pol_wr_i loads pol_wdata_i into the polarity bit, and pol_o shows that bit. With a value of 1, irq_o equals the pending state. With a value of 0, irq_o is its inverse.
- R8: A write strobe without a read strobe leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event pulses, one bit per condition |
| reg_rd_i | input | 1 | Read strobe for the mask/flag register |
| reg_wr_i | input | 1 | Write strobe for the mask/flag register |
| reg_wdata_i | input | 16 | Write data; only bits 15:8 are used |
| reg_rdata_o | output | 16 | Masks in 15:8, flags in 7:0 |
| pol_wr_i | input | 1 | Write strobe for the polarity bit |
| pol_wdata_i | input | 1 | New polarity: 1 means active-high |
| pol_o | output | 1 | Stored polarity bit |
| irq_o | output | 1 | Interrupt pin |

## Verification
Events are first raised with every mask cleared. This separates flag latching from pin drive. Masks are then opened over flags that are already set, which shows that the pin follows the AND of masks and flags and not just the latest event. Reads are issued with and without a coincident event, which tells a correct clear apart from one that drops same-cycle events. Writes carry junk in the low byte and are repeated under both polarities. A long random phase mixes all strobes, and a behavioural model is compared against the outputs on every clock.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef enum logic {
    POL_ACT_LOW  = 1'b0,
    POL_ACT_HIGH = 1'b1
  } irq_pol_e;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N_EVT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             clr_i,
  output logic [N_EVT-1:0] flag_o
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    // new event wins over the clearing read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (evt_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i)    flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int N_EVT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_EVT-1:0] wdata_i,
  output logic [N_EVT-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/evt_pin_drv.sv
module evt_pin_drv
  import evt_irq_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pol_wr_i,
  input  logic             pol_wdata_i,
  input  logic [N_EVT-1:0] mask_i,
  input  logic [N_EVT-1:0] flag_i,
  output logic             pol_o,
  output logic             irq_o
);
  irq_pol_e pol_q;
  logic     pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= POL_ACT_LOW;
    else if (pol_wr_i) pol_q <= irq_pol_e'(pol_wdata_i);
  end

  assign pend  = |(mask_i & flag_i);
  assign pol_o = pol_q;
  assign irq_o = (pol_q == POL_ACT_HIGH) ? pend : ~pend;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int N_EVT = 8,
  localparam int REG_W = 2 * N_EVT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             pol_wr_i,
  input  logic             pol_wdata_i,
  output logic             pol_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] flag;
  logic [N_EVT-1:0] mask;

  evt_flag_bank #(.N_EVT(N_EVT)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (reg_rd_i),
    .flag_o (flag)
  );

  evt_mask_reg #(.N_EVT(N_EVT)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i[REG_W-1:N_EVT]),
    .mask_o  (mask)
  );

  evt_pin_drv #(.N_EVT(N_EVT)) u_pin (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pol_wr_i    (pol_wr_i),
    .pol_wdata_i (pol_wdata_i),
    .mask_i      (mask),
    .flag_i      (flag),
    .pol_o       (pol_o),
    .irq_o       (irq_o)
  );

  assign reg_rdata_o = {mask, flag};
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int N_EVT = 8,
  localparam int REG_W = 2 * N_EVT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_EVT-1:0] evt_i,
  input logic             reg_rd_i,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             pol_wr_i,
  input logic             pol_wdata_i,
  input logic             pol_o,
  input logic             irq_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r2_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> ((reg_rdata_o[N_EVT-1:0] & $past(evt_i)) == $past(evt_i)));

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !reg_rd_i) |=>
      ((reg_rdata_o[N_EVT-1:0] & $past(reg_rdata_o[N_EVT-1:0])) == $past(reg_rdata_o[N_EVT-1:0])));

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && reg_rd_i) |=> (reg_rdata_o[N_EVT-1:0] == $past(evt_i)));

  a_r5_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && reg_wr_i) |=> (reg_rdata_o[REG_W-1:N_EVT] == $past(reg_wdata_i[REG_W-1:N_EVT])));

  a_r5_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !reg_wr_i) |=> $stable(reg_rdata_o[REG_W-1:N_EVT]));

  a_r6_pin_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(reg_rdata_o[REG_W-1:N_EVT] & reg_rdata_o[N_EVT-1:0])) == (irq_o == pol_o));

  a_r7_pol_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && pol_wr_i) |=> (pol_o == $past(pol_wdata_i)));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.N_EVT(N_EVT)) u_chk (.*);

// File: tb/sim_evt_irq_ctrl.sv
module sim_evt_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        reg_rd_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        pol_wr_i = 1'b0;
  logic        pol_wdata_i = 1'b0;
  logic        pol_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_mask = 0;
  int m_flag = 0;
  int m_pol  = 0;

  always #5 clk_i = ~clk_i;

  evt_irq_ctrl u0 (.*);

  // reference model: updated at the active edge from stable inputs
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = 0; m_flag = 0; m_pol = 0;
    end else begin
      m_flag = (reg_rd_i ? 0 : m_flag) | int'(evt_i);
      if (reg_wr_i) m_mask = int'(reg_wdata_i[15:8]);
      if (pol_wr_i) m_pol = int'(pol_wdata_i);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_irq();
    bit pend = ((m_mask & m_flag) != 0);
    return m_pol ? int'(pend) : int'(!pend);
  endfunction

  // compare on every clock, away from the edge
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk("R4 readback", int'(reg_rdata_o), (m_mask << 8) | m_flag);
    chk("R6 R7 pin", int'(irq_o), exp_irq());
    chk("R7 pol_o", int'(pol_o), m_pol);
  end

  task automatic step(input logic [7:0] ev, input logic rd, input logic wr,
                      input logic [15:0] wd, input logic pw, input logic pv);
    evt_i = ev; reg_rd_i = rd; reg_wr_i = wr; reg_wdata_i = wd;
    pol_wr_i = pw; pol_wdata_i = pv;
    @(negedge clk_i);
    evt_i = '0; reg_rd_i = 0; reg_wr_i = 0; reg_wdata_i = '0; pol_wr_i = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 rdata", int'(reg_rdata_o), 0);
    chk("R1 irq", int'(irq_o), 1);
    chk("R1 pol", int'(pol_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: event with no mask latches, pin stays inactive
    step(8'h05, 0, 0, 16'h0, 0, 0);
    chk("R2 latch", int'(reg_rdata_o[7:0]), 8'h05);
    chk("R2 pin idle", int'(irq_o), 1);
    step(8'h00, 0, 0, 16'h0, 0, 0);
    chk("R2 sticky", int'(reg_rdata_o[7:0]), 8'h05);

    // R5 R8: low byte junk ignored, mask over existing flag raises pin (R6)
    step(8'h00, 0, 1, 16'h04FA, 0, 0);
    chk("R5 mask", int'(reg_rdata_o[15:8]), 8'h04);
    chk("R8 flags kept", int'(reg_rdata_o[7:0]), 8'h05);
    chk("R6 assert", int'(irq_o), 0);

    // R7: flip to active-high
    step(8'h00, 0, 0, 16'h0, 1, 1);
    chk("R7 high", int'(irq_o), 1);

    // R3: read with coincident event keeps that event
    step(8'h80, 1, 0, 16'h0, 0, 0);
    chk("R3 clear keep", int'(reg_rdata_o[7:0]), 8'h80);
    chk("R6 deassert", int'(irq_o), 0);
    step(8'h00, 1, 0, 16'h0, 0, 0);
    chk("R3 clear all", int'(reg_rdata_o[7:0]), 0);

    // R6: event on a masked-in bit
    step(8'h04, 0, 0, 16'h0, 0, 0);
    chk("R6 event", int'(irq_o), 1);
    step(8'h00, 0, 0, 16'h0, 1, 0);
    chk("R7 low", int'(irq_o), 0);

    // random mix
    for (int i = 0; i < 400; i++)
      step(8'($urandom) & 8'($urandom), ($urandom % 5) == 0, ($urandom % 6) == 0,
           16'($urandom), ($urandom % 9) == 0, 1'($urandom));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule